// File: doc/BRIEF.md
# Soft-Start, Skip and Overload Supervisor

This block turns a digitised feedback code into the reference that sets the peak-current level of a current-mode power converter, and raises two mode flags. All voltages are unsigned codes in millivolts. After reset and after every start request, a soft-start value climbs from zero by one code step every `SS_DIV` clock cycles. It stops at the full-scale level of 1000 mV. The reference driven out is the smaller of that value and one third of the feedback code, rounded down.

The same feedback code drives a skip comparator. When the code falls well below a threshold, the skip flag asserts so that downstream logic drops switching pulses. The threshold is either a default, a clamped programmed level, or disabled. A separate overload timer runs only while feedback sits above the regulation ceiling. If the timer reaches its limit, a sticky fault flag is set. The fault is released by an explicit clear or by a new start request.

Top module: `mod_ref_supervisor`

## Requirements
- R1: While rst_ni is low, ref_code_o, skip_o and ovld_fault_o are all 0.
- R2: After reset release, the soft-start value rises from 0 by one code every SS_DIV clock cycles. It then holds at SS_FULL (default 1000).
- R3: ref_code_o equals min(soft-start value, floor(fb_code_i / 3)). It is registered, so it follows a feedback change one clock edge later.
- R4: A clock edge with ss_start_i high resets the soft-start value to 0, and the ramp then starts again.
- R5: With an active threshold T, skip_o sets when fb_code_i < T - SKIP_HYS (hysteresis default 75). It clears when fb_code_i > T. Otherwise it holds its value. It is registered, one edge of latency.
- R6: When skip_open_i is 1, T is SKIP_DEF (1100). When skip_open_i is 0 and skip_set_i is 0, skipping is disabled and skip_o is 0. Otherwise T = min(skip_set_i, SKIP_MAX), with SKIP_MAX = 1300.
- R7: The overload timer counts only on edges where fb_code_i > REG_CEIL (3000). Any edge with fb_code_i <= REG_CEIL clears it, and a code exactly at the ceiling never counts.
- R8: ovld_fault_o rises on the OVLD_CYCLES-th consecutive edge with fb_code_i above REG_CEIL.
- R9: ovld_fault_o stays set until an edge with ovld_clr_i or ss_start_i high. Either of these clears both the fault and the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_code_i | input | CODE_W | Feedback code, mV |
| skip_set_i | input | CODE_W | Programmed skip threshold, mV |
| skip_open_i | input | 1 | 1 selects the default skip threshold |
| ss_start_i | input | 1 | Soft-start restart request |
| ovld_clr_i | input | 1 | Clears the overload fault |
| ref_code_o | output | CODE_W | Modulation reference, mV |
| skip_o | output | 1 | Skip-cycle flag |
| ovld_fault_o | output | 1 | Sticky overload fault |

## Verification
The bench drives feedback across both skip edges at exactly T, T+1 and just under T - 75. A comparator with no hysteresis, or with a non-strict edge, would toggle at a different code than expected. The clamp and the disable setting are checked with a level above 1300 and with a zero setting while skip is asserted; a missing clamp keeps skip set past 1300, and a disable that only blocks setting leaves skip stuck high. The overload fault is checked at one cycle short of the limit and exactly at the limit. It is also checked after a brief dip under the ceiling, where a timer that is not cleared fires early, and with feedback held exactly at 3000, which must never count. The min-select is checked with feedback both above and below three times the ramp, including a value that is not a multiple of three.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int CODE_W = 12;
  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic [1:0] {THR_DEF, THR_PROG, THR_OFF} thr_mode_e;
endpackage

// File: rtl/sup_ss_ramp.sv
module sup_ss_ramp
  import sup_pkg::*;
#(
  parameter int SS_DIV  = 960,
  parameter int SS_FULL = 1000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  output code_t ss_o
);
  localparam int    DIV_W  = $clog2(SS_DIV + 1);
  localparam code_t FULL_C = code_t'(SS_FULL);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SS_DIV - 1);

  logic [DIV_W-1:0] div_q;
  code_t            ss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ss_q  <= '0;
    end else if (start_i) begin
      div_q <= '0;
      ss_q  <= '0;
    end else if (ss_q < FULL_C) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        ss_q  <= ss_q + code_t'(1);
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign ss_o = ss_q;

  AST_SS_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ss_q >= $past(ss_q)); // R2
  AST_SS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_q <= FULL_C); // R2
  AST_SS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ss_q == '0); // R4
endmodule

// File: rtl/sup_skip_cmp.sv
module sup_skip_cmp
  import sup_pkg::*;
#(
  parameter int SKIP_DEF = 1100,
  parameter int SKIP_MAX = 1300,
  parameter int SKIP_HYS = 75
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t fb_i,
  input  code_t set_i,
  input  logic  open_i,
  output logic  skip_o
);
  localparam code_t DEF_C = code_t'(SKIP_DEF);
  localparam code_t MAX_C = code_t'(SKIP_MAX);
  localparam code_t HYS_C = code_t'(SKIP_HYS);

  thr_mode_e mode;
  code_t     thr_hi, thr_lo;
  logic      skip_q;

  always_comb begin
    if (open_i)             mode = THR_DEF;
    else if (set_i == '0)   mode = THR_OFF;
    else                    mode = THR_PROG;
  end

  always_comb begin
    unique case (mode)
      THR_DEF:  thr_hi = DEF_C;
      THR_PROG: thr_hi = (set_i > MAX_C) ? MAX_C : set_i;
      default:  thr_hi = '0;
    endcase
    thr_lo = (thr_hi > HYS_C) ? thr_hi - HYS_C : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                skip_q <= 1'b0;
    else if (mode == THR_OFF)   skip_q <= 1'b0;
    else if (fb_i < thr_lo)     skip_q <= 1'b1;
    else if (fb_i > thr_hi)     skip_q <= 1'b0;
  end

  assign skip_o = skip_q;

  AST_SKIP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_i && set_i == '0) |=> !skip_o); // R6
  AST_SKIP_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_i > MAX_C) |=> !skip_o); // R6
  AST_SKIP_SET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(skip_o) |-> $past(fb_i) < $past(thr_hi)); // R5
endmodule

// File: rtl/sup_ovld_timer.sv
module sup_ovld_timer
  import sup_pkg::*;
#(
  parameter int REG_CEIL    = 3000,
  parameter int OVLD_CYCLES = 23_600_000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  code_t fb_i,
  input  logic  clr_i,
  input  logic  start_i,
  output logic  fault_o
);
  localparam int    CNT_W  = $clog2(OVLD_CYCLES + 1);
  localparam code_t CEIL_C = code_t'(REG_CEIL);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fault_q;
  logic             over;

  assign over = fb_i > CEIL_C;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (clr_i || start_i) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (!over) begin
      cnt_q   <= '0;
    end else if (cnt_q == CNT_LAST) begin
      fault_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign fault_o = fault_q;

  AST_FAULT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(fb_i) > CEIL_C); // R8
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !clr_i && !start_i) |=> fault_o); // R9
  AST_FAULT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || start_i) |=> !fault_o); // R9
  AST_TIMER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !over |=> cnt_q == '0); // R7
endmodule

// File: rtl/mod_ref_supervisor.sv
module mod_ref_supervisor
  import sup_pkg::*;
#(
  parameter int SS_DIV      = 960,
  parameter int SS_FULL     = 1000,
  parameter int SKIP_DEF    = 1100,
  parameter int SKIP_MAX    = 1300,
  parameter int SKIP_HYS    = 75,
  parameter int REG_CEIL    = 3000,
  parameter int OVLD_CYCLES = 23_600_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] fb_code_i,
  input  logic [CODE_W-1:0] skip_set_i,
  input  logic              skip_open_i,
  input  logic              ss_start_i,
  input  logic              ovld_clr_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              skip_o,
  output logic              ovld_fault_o
);
  code_t ss_val, fb_div3, ref_q;

  sup_ss_ramp #(.SS_DIV(SS_DIV), .SS_FULL(SS_FULL)) i_ramp (
    .clk_i, .rst_ni, .start_i(ss_start_i), .ss_o(ss_val)
  );

  sup_skip_cmp #(.SKIP_DEF(SKIP_DEF), .SKIP_MAX(SKIP_MAX), .SKIP_HYS(SKIP_HYS)) i_skip (
    .clk_i, .rst_ni, .fb_i(fb_code_i), .set_i(skip_set_i), .open_i(skip_open_i),
    .skip_o
  );

  sup_ovld_timer #(.REG_CEIL(REG_CEIL), .OVLD_CYCLES(OVLD_CYCLES)) i_ovld (
    .clk_i, .rst_ni, .fb_i(fb_code_i), .clr_i(ovld_clr_i), .start_i(ss_start_i),
    .fault_o(ovld_fault_o)
  );

  assign fb_div3 = fb_code_i / code_t'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= (ss_val < fb_div3) ? ss_val : fb_div3;
  end

  assign ref_code_o = ref_q;

  AST_REF_UNDER_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ref_code_o <= $past(ss_val)); // R3
  AST_REF_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_code_o <= code_t'(SS_FULL)); // R2
  AST_REF_UNDER_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (32'(ref_code_o) * 3) <= 32'($past(fb_code_i))); // R3
endmodule

// File: tb/test_mod_ref_supervisor.sv
module test_mod_ref_supervisor;
  localparam int DIV  = 4;
  localparam int OVLD = 200;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] fb_code_i = '0;
  logic [11:0] skip_set_i = '0;
  logic        skip_open_i = 1'b1;
  logic        ss_start_i = 1'b0;
  logic        ovld_clr_i = 1'b0;
  logic [11:0] ref_code_o;
  logic        skip_o;
  logic        ovld_fault_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  mod_ref_supervisor #(.SS_DIV(DIV), .OVLD_CYCLES(OVLD)) i_mod_ref_supervisor (
    .clk_i, .rst_ni, .fb_code_i, .skip_set_i, .skip_open_i, .ss_start_i,
    .ovld_clr_i, .ref_code_o, .skip_o, .ovld_fault_o
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; fb_code_i = 12'd3600;
    step(3);
    chk("R1 ref", ref_code_o, 0);
    chk("R1 skip", skip_o, 0);
    chk("R1 fault", ovld_fault_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_ramp();
    step(400);
    chk_rng("R2 mid ramp", ref_code_o, 97, 101);
    step(3700);
    chk("R2 full", ref_code_o, 1000);
    step(100);
    chk("R2 hold", ref_code_o, 1000);
  endtask

  task automatic t_min();
    fb_code_i = 12'd1500; step(2);
    chk("R3 fb/3", ref_code_o, 500);
    fb_code_i = 12'd1502; step(2);
    chk("R3 floor", ref_code_o, 500);
    fb_code_i = 12'd2; step(2);
    chk("R3 low", ref_code_o, 0);
    fb_code_i = 12'd3600; step(2);
    chk("R3 ramp wins", ref_code_o, 1000);
  endtask

  task automatic t_restart();
    fb_code_i = 12'd1500;
    ss_start_i = 1'b1; step(1); ss_start_i = 1'b0;
    step(40);
    chk_rng("R4 restart", ref_code_o, 8, 11);
    step(4100);
    chk("R4 settle", ref_code_o, 500);
  endtask

  task automatic t_skip_def();
    skip_open_i = 1'b1;
    fb_code_i = 12'd1050; step(2); chk("R5 in band", skip_o, 0);
    fb_code_i = 12'd1020; step(2); chk("R5 set", skip_o, 1);
    fb_code_i = 12'd1080; step(2); chk("R5 hold", skip_o, 1);
    fb_code_i = 12'd1100; step(2); chk("R5 at thr", skip_o, 1);
    fb_code_i = 12'd1101; step(2); chk("R5 clear", skip_o, 0);
    fb_code_i = 12'd1025; step(2); chk("R5 at low", skip_o, 0);
  endtask

  task automatic t_skip_prog();
    skip_open_i = 1'b0; skip_set_i = 12'd1500;
    fb_code_i = 12'd1250; step(2); chk("R6 clamp band", skip_o, 0);
    fb_code_i = 12'd1200; step(2); chk("R6 clamp set", skip_o, 1);
    fb_code_i = 12'd1300; step(2); chk("R6 clamp hold", skip_o, 1);
    fb_code_i = 12'd1301; step(2); chk("R6 clamp clear", skip_o, 0);
    skip_set_i = 12'd600;
    fb_code_i = 12'd530; step(2); chk("R6 prog band", skip_o, 0);
    fb_code_i = 12'd520; step(2); chk("R6 prog set", skip_o, 1);
    skip_set_i = 12'd0; step(2); chk("R6 disable", skip_o, 0);
    fb_code_i = 12'd0; step(2); chk("R6 disable low", skip_o, 0);
    skip_set_i = 12'd600;
    fb_code_i = 12'd601; step(2); chk("R6 prog clear", skip_o, 0);
    skip_open_i = 1'b1;
  endtask

  task automatic t_ovld();
    fb_code_i = 12'd3000; step(300);
    chk("R7 at ceiling", ovld_fault_o, 0);
    fb_code_i = 12'd3100; step(190);
    fb_code_i = 12'd2900; step(2);
    fb_code_i = 12'd3100; step(OVLD - 1);
    chk("R7 dip cleared", ovld_fault_o, 0);
    step(1);
    chk("R8 expire", ovld_fault_o, 1);
    fb_code_i = 12'd1000; step(5);
    chk("R9 sticky", ovld_fault_o, 1);
    ovld_clr_i = 1'b1; step(1); ovld_clr_i = 1'b0; step(1);
    chk("R9 clear", ovld_fault_o, 0);
    fb_code_i = 12'd3100; step(OVLD);
    chk("R8 again", ovld_fault_o, 1);
    fb_code_i = 12'd1000;
    ss_start_i = 1'b1; step(1); ss_start_i = 1'b0; step(1);
    chk("R9 start clears", ovld_fault_o, 0);
  endtask

  initial begin
    #(150_000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_ramp();
    t_min();
    t_restart();
    t_skip_def();
    t_skip_prog();
    t_ovld();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule